// File: doc/BRIEF.md
# Repeating Block Copy Engine

This block moves a run of equal-sized elements from one place in a byte-addressed memory to another. A decode stage supplies three operand values together with a single `start` strobe: a source pointer, a destination pointer and an element count. It also supplies a direction flag, an element-size code and a pointer-width code. The engine moves one byte per memory cycle, and each byte takes a read cycle followed by a write cycle. After each element it steps both pointers by the element size and lowers the count by one. It stops when the count reaches zero.

The pointers and the count are treated as numbers of the selected pointer width. Arithmetic wraps inside that width, and bits above it pass through untouched. The final pointer and count values are therefore ready to be written back into full-width registers. They are presented with a one-cycle write-back strobe.

The control is a four-state machine:
- ST_IDLE waits for `start`. It moves to ST_FINISH when the masked count is zero and to ST_READ otherwise.
- ST_READ issues one byte read and always moves to ST_WRITE.
- ST_WRITE writes the byte just read. It returns to ST_READ for the next byte of the same element. After the last byte it steps the pointers and the count, then goes to ST_READ if elements remain or to ST_FINISH if none do.
- ST_FINISH pulses `done` and `wb_valid` and returns to ST_IDLE.

Top module: `blkcopy_engine`

## Requirements
- R1: While reset is held and in the first cycle after release, `busy`, `done`, `wb_valid`, `mem_rd` and `mem_wr` are all low.
- R2: Size codes are shared by `elem_sz` and `ptr_sz`: code 0 selects 1 byte / 8 bits, 1 selects 2 / 16, 2 selects 4 / 32 and 3 selects 8 / 64. `dir_down` = 0 steps the pointers up and 1 steps them down.
- R3: If the count, masked to the pointer width, is zero when `start` is taken, no memory access occurs, and the final outputs equal the inputs.
- R4: Byte i of an element is read at pointer+i, wrapped at the pointer width, for i rising from 0 (little-endian). It is written one cycle later to the destination pointer+i with the data returned for that read. Read data is expected on `mem_rdata` in the cycle after `mem_rd`.
- R5: In incrementing mode both pointers rise by the element size in bytes after every element.
- R6: In decrementing mode both pointers fall by the element size after every element. Each element is still taken at the current pointer, in ascending byte order.
- R7: The count falls by one per element. When it reaches zero, the final source pointer, destination pointer and count appear on the outputs with `done` and `wb_valid` high for exactly one cycle.
- R8: Pointer and count arithmetic wraps at the selected width, and bits above that width are kept. `mem_addr` carries only the wrapped value, with all higher bits zero.
- R9: `busy` is high from the cycle after `start` is taken through the `done` cycle. A `start` seen while busy is ignored.
- R10: The memory is never read and written in the same cycle.
- R11: For N-byte elements and masked count C, `done` is high in the (2·N·C+1)-th cycle after the edge that takes `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a copy with the operand inputs (taken only when idle) |
| src_ptr | input | REG_W | Initial source pointer |
| dst_ptr | input | REG_W | Initial destination pointer |
| count | input | REG_W | Initial element count |
| dir_down | input | 1 | 0 = increment pointers, 1 = decrement |
| elem_sz | input | 2 | Element size code |
| ptr_sz | input | 2 | Pointer/count width code |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| wb_valid | output | 1 | Final values valid for write-back |
| src_final | output | REG_W | Source pointer after the transfer |
| dst_final | output | REG_W | Destination pointer after the transfer |
| cnt_final | output | REG_W | Count after the transfer |
| mem_addr | output | REG_W | Byte address of the current access |
| mem_rd | output | 1 | Byte read request |
| mem_wr | output | 1 | Byte write request |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 8 | Byte returned one cycle after a read |

## Verification
The bench builds the engine with the default REG_W of 64, so every width code, including the full 64-bit one, is legal. With this width, upper register bits sit above every narrower width. That lets the bench place nonzero upper bits in the pointers and in the count and see them survive an 8-bit wrap. It also lets the bench use a count whose low byte is zero to reach the zero-count path at a narrow width. A 256-byte memory model indexed by the low address byte covers both upward and downward wrap through address zero.

// File: rtl/blkcp_pkg.sv
package blkcp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_READ   = 2'd1,
        ST_WRITE  = 2'd2,
        ST_FINISH = 2'd3
    } blkcp_state_e;

    typedef enum logic [1:0] {
        SZ_B1 = 2'd0,
        SZ_B2 = 2'd1,
        SZ_B4 = 2'd2,
        SZ_B8 = 2'd3
    } blkcp_size_e;

endpackage

// File: rtl/blkcp_width_mask.sv
module blkcp_width_mask #(
    parameter int W = 64
) (
    input  logic [1:0]   wsel,
    output logic [W-1:0] mask
);
    // Low (8 << wsel) bits set, capped at W.
    always_comb begin
        for (int i = 0; i < W; i++) begin
            mask[i] = (i < (8 << wsel));
        end
    end
endmodule

// File: rtl/blkcp_wrap_add.sv
module blkcp_wrap_add #(
    parameter int W          = 64,
    parameter bit KEEP_UPPER = 1'b1
) (
    input  logic [W-1:0] base,
    input  logic [W-1:0] off,
    input  logic         sub,
    input  logic [1:0]   wsel,
    output logic [W-1:0] res
);
    logic [W-1:0] m;
    logic [W-1:0] raw;

    blkcp_width_mask #(.W(W)) u_mask (
        .wsel (wsel),
        .mask (m)
    );

    assign raw = sub ? (base - off) : (base + off);

    generate
        if (KEEP_UPPER) begin : g_merge
            // register write-back form: upper bits carried through
            assign res = (base & ~m) | (raw & m);
        end else begin : g_wrap
            // bus address form: upper bits cleared
            assign res = raw & m;
        end
    endgenerate
endmodule

// File: rtl/blkcopy_engine.sv
module blkcopy_engine
    import blkcp_pkg::*;
#(
    parameter int REG_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [REG_W-1:0] src_ptr,
    input  logic [REG_W-1:0] dst_ptr,
    input  logic [REG_W-1:0] count,
    input  logic             dir_down,
    input  logic [1:0]       elem_sz,
    input  logic [1:0]       ptr_sz,
    output logic             busy,
    output logic             done,
    output logic             wb_valid,
    output logic [REG_W-1:0] src_final,
    output logic [REG_W-1:0] dst_final,
    output logic [REG_W-1:0] cnt_final,
    output logic [REG_W-1:0] mem_addr,
    output logic             mem_rd,
    output logic             mem_wr,
    output logic [7:0]       mem_wdata,
    input  logic [7:0]       mem_rdata
);
    localparam int MAX_BYTES = REG_W / 8;
    localparam int IDX_W     = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1;

    blkcp_state_e      st, st_nx;
    logic [REG_W-1:0]  src_q, dst_q, cnt_q;
    logic              dir_q;
    blkcp_size_e       esz_q;
    logic [1:0]        asz_q;
    logic [IDX_W-1:0]  bidx;

    logic [IDX_W:0]    nbytes;
    logic              last_byte;
    logic [REG_W-1:0]  in_mask, cnt_mask;
    logic [REG_W-1:0]  src_rd_a, dst_wr_a;
    logic [REG_W-1:0]  src_nx, dst_nx, cnt_nx;
    logic              start_zero, cnt_will_zero;

    assign nbytes    = (IDX_W+1)'(1) << esz_q;
    assign last_byte = ({1'b0, bidx} == (nbytes - 1'b1));

    // ---------------- width-aware arithmetic ----------------
    blkcp_width_mask #(.W(REG_W)) u_in_mask (
        .wsel (ptr_sz),
        .mask (in_mask)
    );

    blkcp_width_mask #(.W(REG_W)) u_cnt_mask (
        .wsel (asz_q),
        .mask (cnt_mask)
    );

    blkcp_wrap_add #(.W(REG_W), .KEEP_UPPER(1'b0)) u_src_addr (
        .base (src_q),
        .off  (REG_W'(bidx)),
        .sub  (1'b0),
        .wsel (asz_q),
        .res  (src_rd_a)
    );

    blkcp_wrap_add #(.W(REG_W), .KEEP_UPPER(1'b0)) u_dst_addr (
        .base (dst_q),
        .off  (REG_W'(bidx)),
        .sub  (1'b0),
        .wsel (asz_q),
        .res  (dst_wr_a)
    );

    blkcp_wrap_add #(.W(REG_W), .KEEP_UPPER(1'b1)) u_src_step (
        .base (src_q),
        .off  (REG_W'(nbytes)),
        .sub  (dir_q),
        .wsel (asz_q),
        .res  (src_nx)
    );

    blkcp_wrap_add #(.W(REG_W), .KEEP_UPPER(1'b1)) u_dst_step (
        .base (dst_q),
        .off  (REG_W'(nbytes)),
        .sub  (dir_q),
        .wsel (asz_q),
        .res  (dst_nx)
    );

    blkcp_wrap_add #(.W(REG_W), .KEEP_UPPER(1'b1)) u_cnt_dec (
        .base (cnt_q),
        .off  (REG_W'(1)),
        .sub  (1'b1),
        .wsel (asz_q),
        .res  (cnt_nx)
    );

    assign start_zero    = ((count & in_mask) == '0);
    assign cnt_will_zero = ((cnt_nx & cnt_mask) == '0);

    // ---------------- next state ----------------
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE: begin
                if (start) st_nx = start_zero ? ST_FINISH : ST_READ;
            end
            ST_READ: begin
                st_nx = ST_WRITE;
            end
            ST_WRITE: begin
                if (!last_byte)         st_nx = ST_READ;
                else if (cnt_will_zero) st_nx = ST_FINISH;
                else                    st_nx = ST_READ;
            end
            ST_FINISH: begin
                st_nx = ST_IDLE;
            end
            default: st_nx = ST_IDLE;
        endcase
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // ---------------- operand registers ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q <= '0;
            dst_q <= '0;
            cnt_q <= '0;
            dir_q <= 1'b0;
            esz_q <= SZ_B1;
            asz_q <= 2'd0;
            bidx  <= '0;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    if (start) begin
                        src_q <= src_ptr;
                        dst_q <= dst_ptr;
                        cnt_q <= count;
                        dir_q <= dir_down;
                        esz_q <= blkcp_size_e'(elem_sz);
                        asz_q <= ptr_sz;
                        bidx  <= '0;
                    end
                end
                ST_WRITE: begin
                    if (last_byte) begin
                        src_q <= src_nx;
                        dst_q <= dst_nx;
                        cnt_q <= cnt_nx;
                        bidx  <= '0;
                    end else begin
                        bidx  <= bidx + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        busy      = 1'b0;
        done      = 1'b0;
        wb_valid  = 1'b0;
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        unique case (st)
            ST_IDLE: ;
            ST_READ: begin
                busy     = 1'b1;
                mem_rd   = 1'b1;
                mem_addr = src_rd_a;
            end
            ST_WRITE: begin
                busy      = 1'b1;
                mem_wr    = 1'b1;
                mem_addr  = dst_wr_a;
                mem_wdata = mem_rdata;
            end
            ST_FINISH: begin
                busy     = 1'b1;
                done     = 1'b1;
                wb_valid = 1'b1;
            end
            default: ;
        endcase
    end

    assign src_final = src_q;
    assign dst_final = dst_q;
    assign cnt_final = cnt_q;

endmodule

// File: rtl/blkcopy_engine_chk.sv
module blkcopy_engine_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic busy,
    input logic done,
    input logic mem_rd,
    input logic mem_wr
);
    // R10
    rw_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    // R9
    mem_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr) |-> busy);

    // R4
    rd_then_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> mem_wr);

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    // R9
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));
endmodule

bind blkcopy_engine blkcopy_engine_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .busy   (busy),
    .done   (done),
    .mem_rd (mem_rd),
    .mem_wr (mem_wr)
);

// File: tb/blkcopy_engine_tb.sv
module blkcopy_engine_tb;
    localparam int CLK_PERIOD = 10;
    localparam int W          = 64;

    typedef struct packed {
        logic [63:0] src;
        logic [63:0] dst;
        logic [63:0] cnt;
        logic        down;
        logic [1:0]  esz;
        logic [1:0]  asz;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{64'h10,          64'h80,          64'd4,      1'b0, 2'd0, 2'd0},
        '{64'h20,          64'h90,          64'd3,      1'b0, 2'd1, 2'd1},
        '{64'h40,          64'hA0,          64'd2,      1'b0, 2'd3, 2'd2},
        '{64'h30,          64'hC0,          64'd3,      1'b1, 2'd2, 2'd3},
        '{64'h1234_00FE,   64'hFFFF_FF70,   64'hAB02,   1'b0, 2'd1, 2'd0},
        '{64'h01,          64'h50,          64'd3,      1'b1, 2'd0, 2'd0},
        '{64'h20,          64'h60,          64'h100,    1'b0, 2'd0, 2'd0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [W-1:0]  src_ptr = '0, dst_ptr = '0, count = '0;
    logic          dir_down = 1'b0;
    logic [1:0]    elem_sz = '0, ptr_sz = '0;
    logic          busy, done, wb_valid;
    logic [W-1:0]  src_final, dst_final, cnt_final, mem_addr;
    logic          mem_rd, mem_wr;
    logic [7:0]    mem_wdata;
    logic [7:0]    mem_rdata = '0;

    int n_chk = 0;
    int n_fail = 0;

    blkcopy_engine #(.REG_W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .src_ptr(src_ptr), .dst_ptr(dst_ptr), .count(count),
        .dir_down(dir_down), .elem_sz(elem_sz), .ptr_sz(ptr_sz),
        .busy(busy), .done(done), .wb_valid(wb_valid),
        .src_final(src_final), .dst_final(dst_final), .cnt_final(cnt_final),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // ---------------- memory model ----------------
    logic [7:0]   mem [256];
    logic         mem_init = 1'b0;
    logic [7:0]   seed = '0;
    logic [63:0]  cur_mask = '1;
    int           acc_cnt = 0, hi_err = 0, both_err = 0;

    always @(posedge clk) begin
        if (mem_init) begin
            for (int i = 0; i < 256; i++) mem[i] <= 8'(i * 13) + seed;
            acc_cnt  <= 0;
            hi_err   <= 0;
            both_err <= 0;
        end else begin
            if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];
            if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
            if (mem_rd || mem_wr) begin
                acc_cnt <= acc_cnt + 1;
                if ((mem_addr & ~cur_mask) != 0) hi_err <= hi_err + 1;
            end
            if (mem_rd && mem_wr) both_err <= both_err + 1;
        end
    end

    // ---------------- reference model ----------------
    function automatic logic [63:0] wmask(input logic [1:0] c);
        return (c == 2'd3) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << (8 << c)) - 64'd1);
    endfunction

    function automatic logic [63:0] upd(input logic [63:0] v, input logic [63:0] d,
                                        input logic sub, input logic [1:0] c);
        logic [63:0] m;
        logic [63:0] r;
        m = wmask(c);
        r = sub ? (v - d) : (v + d);
        return (v & ~m) | (r & m);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    logic [7:0] sh [256];

    task automatic run_vec(input vec_t v, input logic [7:0] sd, input bit intrude);
        logic [63:0] m, s, d, c, ec, cnum;
        int nb, n, exp_cyc, bad;
        bit busy_ok;
        m  = wmask(v.asz);
        nb = 1 << v.esz;
        @(negedge clk);
        seed = sd; mem_init = 1'b1; cur_mask = m;
        src_ptr = v.src; dst_ptr = v.dst; count = v.cnt;
        dir_down = v.down; elem_sz = v.esz; ptr_sz = v.asz;
        @(negedge clk);
        mem_init = 1'b0;
        // expected result (R4, R5, R6, R7, R8)
        for (int i = 0; i < 256; i++) sh[i] = 8'(i * 13) + sd;
        s = v.src; d = v.dst; c = v.cnt;
        cnum = v.cnt & m;
        for (longint e = 0; e < longint'(cnum); e++) begin
            for (int b = 0; b < nb; b++) begin
                logic [63:0] sa, da;
                sa = (s + 64'(b)) & m;
                da = (d + 64'(b)) & m;
                sh[da[7:0]] = sh[sa[7:0]];
            end
            s = upd(s, 64'(nb), v.down, v.asz);
            d = upd(d, 64'(nb), v.down, v.asz);
            c = upd(c, 64'd1, 1'b1, v.asz);
        end
        ec = c;
        exp_cyc = 2 * nb * int'(cnum) + 1;
        // launch
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 1;
        busy_ok = 1'b1;
        while (!done && n < 5000) begin
            if (!busy) busy_ok = 1'b0;
            if (intrude && n == 3) begin
                start = 1'b1; src_ptr = 64'hAA; dst_ptr = 64'h11;
                count = 64'd9; dir_down = ~v.down;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            n++;
        end
        start = 1'b0;
        chk(busy_ok && busy, "R9 busy through transfer", {63'd0, busy_ok}, 64'd1);
        chk(n == exp_cyc, "R11 cycles to done", 64'(n), 64'(exp_cyc));
        chk(wb_valid, "R7 wb_valid with done", {63'd0, wb_valid}, 64'd1);
        chk(src_final == s, v.down ? "R6 final source" : "R5 final source", src_final, s);
        chk(dst_final == d, "R5/R6 final destination R8", dst_final, d);
        chk(cnt_final == ec, "R7 final count R8", cnt_final, ec);
        chk(acc_cnt == 2 * nb * int'(cnum), "R3 memory access count",
            64'(acc_cnt), 64'(2 * nb * int'(cnum)));
        chk(hi_err == 0, "R8 address bits above width", 64'(hi_err), 64'd0);
        chk(both_err == 0, "R10 read and write together", 64'(both_err), 64'd0);
        bad = 0;
        for (int i = 0; i < 256; i++) if (mem[i] !== sh[i]) bad++;
        chk(bad == 0, "R4 memory contents", 64'(bad), 64'd0);
        @(negedge clk);
        chk(!done && !busy, "R7 done one cycle", {62'd0, done, busy}, 64'd0);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog R11 actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    // ---------------- main ----------------
    initial begin
        repeat (3) @(negedge clk);
        // R1 during reset
        chk({busy, done, wb_valid, mem_rd, mem_wr} == 5'b0, "R1 outputs in reset",
            64'({busy, done, wb_valid, mem_rd, mem_wr}), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({busy, done, wb_valid, mem_rd, mem_wr} == 5'b0, "R1 outputs after reset",
            64'({busy, done, wb_valid, mem_rd, mem_wr}), 64'd0);

        // vector table: R2 codes, R5/R6 directions, R8 wrap, R3 zero count (last entry)
        for (int k = 0; k < NV; k++) begin
            run_vec(VECS[k], 8'(k * 29 + 5), 1'b0);
        end

        // R9: start asserted mid-transfer is ignored
        run_vec(VECS[1], 8'h3C, 1'b1);

        // R3 directed: true zero count at 64-bit width
        run_vec('{64'hDEAD_0000_0000_0010, 64'h70, 64'd0, 1'b1, 2'd3, 2'd3}, 8'h77, 1'b0);

        // R8 directed: 16-bit wrap downward through address zero
        run_vec('{64'h5555_0002, 64'h9999_00F0, 64'h7777_0002, 1'b1, 2'd2, 2'd1}, 8'h42, 1'b0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule